// File: doc/BRIEF.md
# Edge-Interrupt UART Transmitter

This block is the transmit half of a serial port that runs without a deep FIFO. A single-byte holding register sits in front of a frame shift register. Software writes bytes through a small register write port. A byte that arrives while the shifter is free goes straight into the shifter, and a byte that arrives while a character is on the line waits in the holding register. The character format is set by configuration inputs: 5 to 8 data bits, an optional even or odd parity bit, and one or two stop bits. Bit timing comes from a one-cycle baud strobe.

The transmit interrupt is driven by an event, not by a level. Its raw latch sets only when a byte held in the holding register moves into the shifter, which leaves the holding register empty. The latch is cleared by a write to the clear address or by a later byte that lands in the holding register. An empty holding register alone never raises the interrupt. A mask input gates the interrupt pin, and the raw latch keeps recording while the pin is masked. A flag word reports transmitter activity at bit 3 and holding-register occupancy at bit 5.

Top module: `tx_hold_irq_uart`

## Requirements
- R1: After reset the line is high, the flag word is zero and both the raw interrupt and the interrupt pin are low. They stay low while the mask is open and nothing has been written.
- R2: A data write (address 0) while the shifter is idle goes straight to the shifter. The flag word shows bit 3 set and bit 5 clear in the following cycle, and the raw interrupt does not change.
- R3: A data write while a character is being shifted stores the byte in the holding register. Flag bit 5 reads 1 from the next cycle and the raw interrupt is cleared.
- R4: When the last bit period of a character ends with the holding register full, the held byte starts at once with its start bit, with no idle bit between the two characters. In the next cycle flag bit 5 reads 0 and the raw interrupt reads 1.
- R5: A data write in the very cycle in which the shifter finishes its last bit with the holding register empty bypasses the holding register. Flag bit 5 stays 0, and the raw interrupt neither changes then nor sets when that character ends.
- R6: A write to address 1 clears the raw interrupt and the interrupt pin from the next cycle.
- R7: Flag bit 3 is 1 while either register holds a byte. It falls in the cycle after the baud strobe that ends the final stop bit of the last character.
- R8: A frame is a low start bit, then N data bits LSB first (N = 5 + code, code 0..3), then a parity bit if enabled, then 1 or 2 high stop bits. The parity bit makes the count of ones over the data and parity bits even (odd-select 0) or odd (odd-select 1). Each bit lasts from one baud strobe to the next, and the start bit begins at the first strobe that falls on or after the load.
- R9: The interrupt pin equals the raw interrupt ANDed with the mask-enable input. The raw latch sets on a drain event even while the pin is masked.
- R10: A data write while the holding register is full and the shifter cannot take a byte is dropped. The held byte is unchanged and only the earlier bytes appear on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | One-cycle strobe marking each bit-period boundary |
| cfg_len_i | input | 2 | Data-length code, N = 5 + code |
| cfg_par_en_i | input | 1 | Parity bit enable |
| cfg_par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop_i | input | 1 | 1 selects two stop bits |
| irq_en_i | input | 1 | Interrupt pin mask enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: 0 data, 1 interrupt clear |
| wr_data_i | input | 8 | Write data byte |
| flags_o | output | FLAG_W | Bit 3 busy, bit 5 holding register full, others 0 |
| txd_o | output | 1 | Serial output, idles high |
| tx_irq_o | output | 1 | Masked transmit interrupt |
| tx_irq_raw_o | output | 1 | Raw transmit interrupt latch |

## Verification
Single writes are placed both on and off a baud strobe. This separates a start bit that begins at once from one that waits for the next strobe, and each of the four format settings is decoded from the line to confirm the bit order, the parity sense and the stop-bit count. Two bytes written close together, with a third added during the second character, show that a drain sets the raw latch while a refill or a clear write drops it. The same run shows that frames follow each other with no gap and that the mask affects only the pin. A write timed exactly to the shifter's final strobe is what tells a bypass apart from a pass through the holding register, since only a pass through the holding register raises the interrupt. A third write made while the holding register is full shows that the overflowing byte is dropped.

// File: rtl/utx_pkg.sv
package utx_pkg;
    localparam int MAX_DBITS = 8;
    localparam int MIN_DBITS = 5;
    localparam int FRAME_W   = MAX_DBITS + 4;
    localparam int CNT_W     = $clog2(FRAME_W + 1);
    localparam int FLAG_BUSY = 3;
    localparam int FLAG_FULL = 5;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } utx_cfg_t;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_WAIT = 2'd1,
        SH_SEND = 2'd2
    } sh_state_e;
endpackage

// File: rtl/utx_frame_pack.sv
module utx_frame_pack
    import utx_pkg::*;
(
    input  utx_cfg_t                cfg_i,
    input  logic [MAX_DBITS-1:0]    byte_i,
    output logic [FRAME_W-1:0]      frame_o,
    output logic [CNT_W-1:0]        len_o
);
    always_comb begin
        int   nb;
        logic par;
        nb      = MIN_DBITS + int'(cfg_i.len_code);
        par     = cfg_i.par_odd;
        frame_o = '1;
        frame_o[0] = 1'b0;
        for (int i = 0; i < MAX_DBITS; i++) begin
            if (i < nb) begin
                frame_o[1 + i] = byte_i[i];
                par            = par ^ byte_i[i];
            end
        end
        for (int j = MIN_DBITS + 1; j < FRAME_W; j++) begin
            if (cfg_i.par_en && (j == nb + 1)) begin
                frame_o[j] = par;
            end
        end
        len_o = CNT_W'(2 + nb + int'(cfg_i.par_en) + int'(cfg_i.two_stop));
    end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CNT_W-1:0]   len_i,
    output logic               free_o,
    output logic               busy_o,
    output logic               txd_o
);
    typedef struct packed {
        sh_state_e          st;
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
    } sh_regs_t;

    sh_regs_t q, d;
    logic last_bit;

    always_comb begin
        last_bit = (q.st == SH_SEND) && tick_i && (q.cnt == CNT_W'(1));
        free_o   = (q.st == SH_IDLE) || last_bit;
        d        = q;
        case (q.st)
            SH_WAIT: begin
                if (tick_i) d.st = SH_SEND;
            end
            SH_SEND: begin
                if (tick_i) begin
                    if (q.cnt == CNT_W'(1)) begin
                        d.st = SH_IDLE;
                    end else begin
                        d.sr  = {1'b1, q.sr[FRAME_W-1:1]};
                        d.cnt = q.cnt - CNT_W'(1);
                    end
                end
            end
            default: ;
        endcase
        if (load_i) begin
            d.sr  = frame_i;
            d.cnt = len_i;
            d.st  = tick_i ? SH_SEND : SH_WAIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= SH_IDLE;
            q.sr  <= '1;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != SH_IDLE);
    assign txd_o  = (q.st == SH_SEND) ? q.sr[0] : 1'b1;

    assert_load_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> free_o);
    assert_count_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SH_SEND) |-> (q.cnt != '0));
    assert_start_bit_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && tick_i) |=> (txd_o == 1'b0));
endmodule

// File: rtl/utx_hold_ctl.sv
module utx_hold_ctl
    import utx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_byte_i,
    input  logic                 wr_clear_i,
    input  logic [MAX_DBITS-1:0] byte_i,
    input  logic                 shf_free_i,
    output logic                 load_o,
    output logic [MAX_DBITS-1:0] load_byte_o,
    output logic                 full_o,
    output logic                 irq_raw_o
);
    typedef struct packed {
        logic [MAX_DBITS-1:0] hb;
        logic                 full;
        logic                 irq;
    } hold_regs_t;

    hold_regs_t q, d;
    logic pop, bypass, push;

    always_comb begin
        pop    = q.full && shf_free_i;
        bypass = wr_byte_i && !q.full && shf_free_i;
        push   = wr_byte_i && !bypass && (!q.full || pop);

        load_o      = pop || bypass;
        load_byte_o = pop ? q.hb : byte_i;

        d      = q;
        d.full = push || (q.full && !pop);
        if (push) d.hb = byte_i;

        if (push)            d.irq = 1'b0;
        else if (pop)        d.irq = 1'b1;
        else if (wr_clear_i) d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.hb   <= '0;
            q.full <= 1'b0;
            q.irq  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign full_o    = q.full;
    assign irq_raw_o = q.irq;

    assert_irq_rise_on_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq) |-> ($past(q.full) && !q.full));
    assert_bypass_keeps_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_i && !q.full && shf_free_i) |=> $stable(q.irq));
    assert_refill_clears_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_i && (q.full == shf_free_i)) |=> !q.irq);
    assert_overflow_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && !shf_free_i) |=> $stable(q.hb));
endmodule

// File: rtl/tx_hold_irq_uart.sv
module tx_hold_irq_uart
    import utx_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int ADDR_DATA = 0,
    parameter int ADDR_CLR  = 1,
    parameter int FLAG_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick_i,
    input  logic [1:0]           cfg_len_i,
    input  logic                 cfg_par_en_i,
    input  logic                 cfg_par_odd_i,
    input  logic                 cfg_two_stop_i,
    input  logic                 irq_en_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [MAX_DBITS-1:0] wr_data_i,
    output logic [FLAG_W-1:0]    flags_o,
    output logic                 txd_o,
    output logic                 tx_irq_o,
    output logic                 tx_irq_raw_o
);
    utx_cfg_t             cfg;
    logic                 wr_byte, wr_clear;
    logic                 shf_free, shf_busy;
    logic                 load;
    logic [MAX_DBITS-1:0] load_byte;
    logic                 hold_full;
    logic [FRAME_W-1:0]   frame;
    logic [CNT_W-1:0]     frame_len;

    always_comb begin
        cfg.len_code = cfg_len_i;
        cfg.par_en   = cfg_par_en_i;
        cfg.par_odd  = cfg_par_odd_i;
        cfg.two_stop = cfg_two_stop_i;
        wr_byte      = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_DATA));
        wr_clear     = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CLR));
    end

    utx_hold_ctl u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_byte_i   (wr_byte),
        .wr_clear_i  (wr_clear),
        .byte_i      (wr_data_i),
        .shf_free_i  (shf_free),
        .load_o      (load),
        .load_byte_o (load_byte),
        .full_o      (hold_full),
        .irq_raw_o   (tx_irq_raw_o)
    );

    utx_frame_pack u_pack (
        .cfg_i   (cfg),
        .byte_i  (load_byte),
        .frame_o (frame),
        .len_o   (frame_len)
    );

    utx_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (baud_tick_i),
        .load_i  (load),
        .frame_i (frame),
        .len_i   (frame_len),
        .free_o  (shf_free),
        .busy_o  (shf_busy),
        .txd_o   (txd_o)
    );

    always_comb begin
        flags_o            = '0;
        flags_o[FLAG_BUSY] = shf_busy || hold_full;
        flags_o[FLAG_FULL] = hold_full;
        tx_irq_o           = tx_irq_raw_o && irq_en_i;
    end

    assert_full_means_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FLAG_FULL] |-> flags_o[FLAG_BUSY]);
    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_o[FLAG_BUSY] |-> txd_o);
endmodule

// File: tb/tx_hold_irq_uart_tb.sv
module tx_hold_irq_uart_tb_top;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_pe = 1'b0, cfg_po = 1'b0, cfg_ts = 1'b0;
    logic       irq_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] flags;
    logic       txd, irq, irq_raw;

    int cyc = 0;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    bit samp [0:4095];
    int ns = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign tick = ((cyc % DIV) == DIV - 1);

    always @(negedge clk) begin
        if (rst_n && ((cyc % DIV) == DIV / 2) && ns < 4096) begin
            samp[ns] = txd;
            ns++;
        end
    end

    tx_hold_irq_uart dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick_i(tick),
        .cfg_len_i(cfg_len), .cfg_par_en_i(cfg_pe), .cfg_par_odd_i(cfg_po),
        .cfg_two_stop_i(cfg_ts), .irq_en_i(irq_en),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .flags_o(flags), .txd_o(txd), .tx_irq_o(irq), .tx_irq_raw_o(irq_raw)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic at_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wait_tick();
        while (!tick) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input int code, input bit pe, input bit po, input bit ts);
        cfg_len = 2'(code); cfg_pe = pe; cfg_po = po; cfg_ts = ts;
    endtask

    function automatic int flen();
        return 2 + 5 + int'(cfg_len) + int'(cfg_pe) + int'(cfg_ts);
    endfunction

    task automatic decode_next(inout int idx, output int val, output int gap, output bit ok);
        int nb;
        bit par;
        nb = 5 + int'(cfg_len);
        val = 0; gap = 0; ok = 1'b1; par = cfg_po;
        while (idx < ns && samp[idx] == 1'b1) begin gap++; idx++; end
        if (idx + flen() > ns) begin ok = 1'b0; return; end
        idx++;
        for (int i = 0; i < nb; i++) begin
            val = val | (int'(samp[idx]) << i);
            par = par ^ samp[idx];
            idx++;
        end
        if (cfg_pe) begin
            if (samp[idx] != par) ok = 1'b0;
            idx++;
        end
        for (int k = 0; k < 1 + int'(cfg_ts); k++) begin
            if (samp[idx] != 1'b1) ok = 1'b0;
            idx++;
        end
    endtask

    task automatic expect_frame(inout int idx, input int exp, input int gap_exp,
                                input string req);
        int v, g;
        bit ok;
        int mask;
        mask = (1 << (5 + int'(cfg_len))) - 1;
        decode_next(idx, v, g, ok);
        eq(req, "frame parity/stop well-formed", int'(ok), 1);
        eq(req, "decoded data", v, exp & mask);
        if (gap_exp >= 0) eq(req, "idle bits before frame", g, gap_exp);
    endtask

    task automatic t_reset();
        eq("R1", "txd after reset", int'(txd), 1);
        eq("R1", "flags after reset", int'(flags), 0);
        eq("R1", "raw irq after reset", int'(irq_raw), 0);
        irq_en = 1'b1;
        repeat (40) @(negedge clk);
        eq("R1", "irq pin with mask open and no data", int'(irq), 0);
        eq("R1", "raw irq with no data", int'(irq_raw), 0);
        irq_en = 1'b0;
    endtask

    task automatic t_late_start();
        int s, c0, idx;
        set_cfg(3, 0, 0, 0);
        while ((cyc % DIV) != 2) @(negedge clk);
        s = ns; c0 = cyc;
        wr(2'd0, 8'h5A);
        eq("R2", "busy after bypass write", int'(flags[3]), 1);
        eq("R2", "full after bypass write", int'(flags[5]), 0);
        eq("R2", "raw irq after bypass write", int'(irq_raw), 0);
        at_cyc(c0 + (DIV - 1) - 2);
        eq("R8", "line idle until first strobe", int'(txd), 1);
        @(negedge clk);
        eq("R8", "start bit after first strobe", int'(txd), 0);
        while (flags[3]) @(negedge clk);
        idx = s;
        expect_frame(idx, 8'h5A, -1, "R8");
    endtask

    task automatic t_format(input int code, input bit pe, input bit po, input bit ts,
                            input logic [7:0] b);
        int s, c0, idx, ld;
        set_cfg(code, pe, po, ts);
        wait_tick();
        s = ns; c0 = cyc; ld = flen() * DIV;
        wr(2'd0, b);
        eq("R8", "start bit right after write on strobe", int'(txd), 0);
        at_cyc(c0 + ld);
        eq("R7", "busy during last stop bit", int'(flags[3]), 1);
        @(negedge clk);
        eq("R7", "busy falls after final stop bit", int'(flags[3]), 0);
        idx = s;
        expect_frame(idx, int'(b), -1, "R8");
    endtask

    task automatic t_back_to_back();
        int s, c0, idx, ld;
        set_cfg(3, 0, 0, 0);
        irq_en = 1'b0;
        wait_tick();
        s = ns; c0 = cyc; ld = flen() * DIV;
        wr(2'd0, 8'h31);
        at_cyc(c0 + 3);
        wr(2'd0, 8'hC4);
        eq("R3", "full after write during shift", int'(flags[5]), 1);
        eq("R3", "busy with byte held", int'(flags[3]), 1);
        eq("R3", "raw irq after refill", int'(irq_raw), 0);
        at_cyc(c0 + ld);
        eq("R4", "full before drain", int'(flags[5]), 1);
        @(negedge clk);
        eq("R4", "raw irq after drain", int'(irq_raw), 1);
        eq("R4", "full clears on drain", int'(flags[5]), 0);
        eq("R9", "pin stays low while masked", int'(irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        eq("R9", "pin follows raw when unmasked", int'(irq), 1);
        at_cyc(c0 + ld + 3);
        wr(2'd0, 8'h9E);
        eq("R3", "full after second refill", int'(flags[5]), 1);
        eq("R3", "raw irq cleared by refill", int'(irq_raw), 0);
        eq("R3", "pin cleared by refill", int'(irq), 0);
        at_cyc(c0 + 2 * ld + 1);
        eq("R4", "raw irq after second drain", int'(irq_raw), 1);
        wr(2'd1, 8'h00);
        eq("R6", "raw irq after clear write", int'(irq_raw), 0);
        eq("R6", "pin after clear write", int'(irq), 0);
        at_cyc(c0 + 3 * ld);
        eq("R7", "busy until last character ends", int'(flags[3]), 1);
        @(negedge clk);
        eq("R7", "busy falls after three characters", int'(flags[3]), 0);
        idx = s;
        expect_frame(idx, 8'h31, -1, "R8");
        expect_frame(idx, 8'hC4, 0, "R4");
        expect_frame(idx, 8'h9E, 0, "R4");
    endtask

    task automatic t_coincide();
        int s, c0, idx, ld;
        set_cfg(2, 1, 0, 0);
        wait_tick();
        s = ns; c0 = cyc; ld = flen() * DIV;
        wr(2'd0, 8'h4B);
        eq("R5", "raw irq before coincident write", int'(irq_raw), 0);
        at_cyc(c0 + ld);
        wr(2'd0, 8'h27);
        eq("R5", "full stays clear on coincident write", int'(flags[5]), 0);
        eq("R5", "raw irq unchanged on coincident write", int'(irq_raw), 0);
        eq("R5", "busy on coincident write", int'(flags[3]), 1);
        at_cyc(c0 + 2 * ld + 1);
        eq("R5", "no irq when bypassed character ends", int'(irq_raw), 0);
        eq("R7", "busy falls after bypassed character", int'(flags[3]), 0);
        idx = s;
        expect_frame(idx, 8'h4B, -1, "R8");
        expect_frame(idx, 8'h27, 0, "R5");
    endtask

    task automatic t_overrun();
        int s, c0, idx, ld, v, g;
        bit ok;
        set_cfg(0, 0, 0, 1);
        wait_tick();
        s = ns; c0 = cyc; ld = flen() * DIV;
        wr(2'd0, 8'h15);
        at_cyc(c0 + 2);
        wr(2'd0, 8'h0A);
        at_cyc(c0 + 4);
        wr(2'd0, 8'h1F);
        eq("R10", "full after dropped write", int'(flags[5]), 1);
        at_cyc(c0 + 2 * ld + 1);
        eq("R10", "busy falls after two characters", int'(flags[3]), 0);
        eq("R4", "raw irq after drain", int'(irq_raw), 1);
        repeat (3 * DIV) @(negedge clk);
        idx = s;
        expect_frame(idx, 8'h15, -1, "R10");
        expect_frame(idx, 8'h0A, 0, "R10");
        decode_next(idx, v, g, ok);
        eq("R10", "no third frame on the line", int'(ok), 0);
        wr(2'd1, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_late_start();
        t_format(0, 1, 0, 1, 8'h13);
        t_format(1, 1, 1, 0, 8'h2D);
        t_format(2, 1, 0, 0, 8'h55);
        t_format(3, 1, 1, 1, 8'hE7);
        t_back_to_back();
        t_coincide();
        t_overrun();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule